// File: doc/BRIEF.md
# Interface Power-State and Clock-Gating Controller

This block tracks the power state of a framed serial interface and decides whether the interface's bit clock and frame-sync outputs run. It takes commands from a 4-bit command/indicate channel with a valid strobe, a configuration-select bit, a software power-up bit and a line-active input. It reports the current state as a 4-bit indication code.

Four states exist: powered down, powered up, activating and active. The configuration-select bit picks the clock policy. When it is clear, the clocks always run, and the powered-down and powered-up states differ only in the code they report. When it is set, the clocks stop in the powered-down state. In that setting, software brings the interface back up either with its power-up bit or by clearing the configuration bit. An activate request then starts line activation.

Clock and frame-sync enables change only on a frame boundary, marked by a one-cycle `frame_tick`, so no partial frame is produced. Frame sync returns a set number of frame boundaries after the clock, so the far end sees a running clock before the first frame mark.

Top module: `ifc_power_ctrl`

## Requirements
- R1: After reset the state is powered down, `ind_code` is 4'b1111, and both `clk_en` and `fsync_en` are 1.
- R2: The indication codes are powered down 4'b1111, powered up 4'b0111, activating 4'b0100 and active 4'b1100. `ind_code` shows the new state from the clock edge at which the causing input is sampled.
- R3: The command codes are timing 4'b0000, activate request 4'b1000 and deactivation 4'b1111. Any other code, or any code while `cmd_valid` is 0, leaves the state unchanged.
- R4: A deactivation command moves every state to powered down.
- R5: With `cfg_sel`=0, a timing command moves powered down to powered up, and an activate request moves powered down straight to activating.
- R6: With `cfg_sel`=1, timing commands and activate requests are ignored in the powered-down state.
- R7: From powered down, `sw_pwrup`=1, or a 1-to-0 change of `cfg_sel`, moves the state to powered up.
- R8: An activate request moves powered up to activating. While activating, `line_active`=1 moves the state to active.
- R9: The target clock enable is 0 only when the state is powered down and `cfg_sel`=1; otherwise it is 1.
- R10: `clk_en` and `fsync_en` change only at a clock edge where `frame_tick`=1. At such an edge `clk_en` takes the target value from R9.
- R11: `fsync_en` falls at the same boundary as `clk_en`. It rises FSYNC_LAG boundaries after `clk_en` rises (one boundary by default). `fsync_en`=1 is never seen with `clk_en`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 4 | Command code |
| cfg_sel | input | 1 | Clock policy select (1 = stop clocks when powered down) |
| sw_pwrup | input | 1 | Software power-up request |
| line_active | input | 1 | Line reports activation complete |
| frame_tick | input | 1 | One-cycle frame boundary marker |
| ind_code | output | 4 | State indication code |
| clk_en | output | 1 | Interface clock enable |
| fsync_en | output | 1 | Frame-sync enable |

## Verification
State results are due one clock edge after the input is sampled. The bench drives each input on a falling edge and reads `ind_code` on the next falling edge, with exactly one rising edge in between. Every start state is combined with every one of the 16 command codes under both settings of `cfg_sel`, and each result is compared with a next-state table written in the bench. Enable results are due only at a frame boundary. The bench therefore reads `clk_en` and `fsync_en` both after a state change without a tick, where they must be unchanged, and again after each separate one-cycle `frame_tick` pulse.

// File: rtl/ifc_power_pkg.sv
package ifc_power_pkg;
  localparam int CMD_W = 4;
  localparam int IND_W = 4;

  typedef enum logic [1:0] {
    PS_DOWN   = 2'd0,
    PS_UP     = 2'd1,
    PS_ARMING = 2'd2,
    PS_LIVE   = 2'd3
  } pwr_state_t;

  localparam logic [CMD_W-1:0] CMD_TIMING = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_ACTREQ = 4'b1000;
  localparam logic [CMD_W-1:0] CMD_DEACT  = 4'b1111;

  localparam logic [IND_W-1:0] IND_DOWN   = 4'b1111;
  localparam logic [IND_W-1:0] IND_UP     = 4'b0111;
  localparam logic [IND_W-1:0] IND_ARMING = 4'b0100;
  localparam logic [IND_W-1:0] IND_LIVE   = 4'b1100;

  function automatic logic [IND_W-1:0] ind_of(pwr_state_t s);
    case (s)
      PS_DOWN:   ind_of = IND_DOWN;
      PS_UP:     ind_of = IND_UP;
      PS_ARMING: ind_of = IND_ARMING;
      default:   ind_of = IND_LIVE;
    endcase
  endfunction
endpackage

// File: rtl/ifc_cmd_decode.sv
module ifc_cmd_decode
  import ifc_power_pkg::*;
(
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output logic             go_timing,
  output logic             go_actreq,
  output logic             go_deact
);
  always_comb begin
    go_timing = 1'b0;
    go_actreq = 1'b0;
    go_deact  = 1'b0;
    if (cmd_valid) begin
      case (cmd_code)
        CMD_TIMING: go_timing = 1'b1;
        CMD_ACTREQ: go_actreq = 1'b1;
        CMD_DEACT:  go_deact  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ifc_pwr_fsm.sv
module ifc_pwr_fsm
  import ifc_power_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             go_timing,
  input  logic             go_actreq,
  input  logic             go_deact,
  input  logic             cfg_sel,
  input  logic             sw_pwrup,
  input  logic             line_active,
  output pwr_state_t       state,
  output logic [IND_W-1:0] ind_code
);
  pwr_state_t state_nx;
  logic       cfg_q;
  logic       cfg_fall;

  assign cfg_fall = cfg_q & ~cfg_sel;

  always_comb begin
    state_nx = state;
    if (go_deact) begin
      state_nx = PS_DOWN;
    end else begin
      case (state)
        PS_DOWN: begin
          if (!cfg_sel && go_actreq)      state_nx = PS_ARMING;
          else if (!cfg_sel && go_timing) state_nx = PS_UP;
          else if (sw_pwrup || cfg_fall)  state_nx = PS_UP;
        end
        PS_UP:     if (go_actreq)   state_nx = PS_ARMING;
        PS_ARMING: if (line_active) state_nx = PS_LIVE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PS_DOWN;
      ind_code <= IND_DOWN;
      cfg_q    <= 1'b0;
    end else begin
      state    <= state_nx;
      ind_code <= ind_of(state_nx);
      cfg_q    <= cfg_sel;
    end
  end

  // R4
  deact_to_down_chk: assert property (@(posedge clk) disable iff (rst)
    go_deact |=> (ind_code == IND_DOWN));

  // R6
  down_cfg1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PS_DOWN && cfg_sel && !sw_pwrup && !cfg_fall) |=> (state == PS_DOWN));

  // R8
  arm_to_live_chk: assert property (@(posedge clk) disable iff (rst)
    (state == PS_ARMING && line_active && !go_deact) |=> (ind_code == IND_LIVE));

  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!go_timing && !go_actreq && !go_deact && !sw_pwrup && !cfg_fall && !line_active)
      |=> $stable(state));
endmodule

// File: rtl/ifc_clk_gate.sv
module ifc_clk_gate
  import ifc_power_pkg::*;
#(
  parameter int FSYNC_LAG = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  pwr_state_t state,
  input  logic       cfg_sel,
  input  logic       frame_tick,
  output logic       clk_en,
  output logic       fsync_en
);
  localparam int LAG_W = (FSYNC_LAG < 2) ? 1 : $clog2(FSYNC_LAG);

  logic             want_on;
  logic [LAG_W-1:0] lag_cnt;

  assign want_on = !(cfg_sel && state == PS_DOWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en   <= 1'b1;
      fsync_en <= 1'b1;
      lag_cnt  <= '0;
    end else if (frame_tick) begin
      if (!want_on) begin
        clk_en   <= 1'b0;
        fsync_en <= 1'b0;
        lag_cnt  <= '0;
      end else if (!clk_en) begin
        clk_en   <= 1'b1;
        lag_cnt  <= '0;
      end else if (!fsync_en) begin
        if (lag_cnt == LAG_W'(FSYNC_LAG - 1)) fsync_en <= 1'b1;
        else                                  lag_cnt  <= lag_cnt + 1'b1;
      end
    end
  end

  // R10
  clk_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(clk_en));

  // R10
  fsync_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(fsync_en));

  // R11
  fsync_needs_clk_chk: assert property (@(posedge clk) disable iff (rst)
    fsync_en |-> clk_en);

  // R9
  stop_at_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && cfg_sel && state == PS_DOWN) |=> !clk_en);
endmodule

// File: rtl/ifc_power_ctrl.sv
module ifc_power_ctrl
  import ifc_power_pkg::*;
#(
  parameter int FSYNC_LAG = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             cfg_sel,
  input  logic             sw_pwrup,
  input  logic             line_active,
  input  logic             frame_tick,
  output logic [IND_W-1:0] ind_code,
  output logic             clk_en,
  output logic             fsync_en
);
  logic       go_timing;
  logic       go_actreq;
  logic       go_deact;
  pwr_state_t state;

  ifc_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .go_timing (go_timing),
    .go_actreq (go_actreq),
    .go_deact  (go_deact)
  );

  ifc_pwr_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .go_timing   (go_timing),
    .go_actreq   (go_actreq),
    .go_deact    (go_deact),
    .cfg_sel     (cfg_sel),
    .sw_pwrup    (sw_pwrup),
    .line_active (line_active),
    .state       (state),
    .ind_code    (ind_code)
  );

  ifc_clk_gate #(.FSYNC_LAG(FSYNC_LAG)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .state      (state),
    .cfg_sel    (cfg_sel),
    .frame_tick (frame_tick),
    .clk_en     (clk_en),
    .fsync_en   (fsync_en)
  );
endmodule

// File: tb/ifc_power_ctrl_test.sv
module ifc_power_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'h0;
  logic       cfg_sel = 1'b0;
  logic       sw_pwrup = 1'b0;
  logic       line_active = 1'b0;
  logic       frame_tick = 1'b0;
  logic [3:0] ind_code;
  logic       clk_en;
  logic       fsync_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ifc_power_ctrl uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cfg_sel(cfg_sel), .sw_pwrup(sw_pwrup), .line_active(line_active),
    .frame_tick(frame_tick), .ind_code(ind_code), .clk_en(clk_en),
    .fsync_en(fsync_en)
  );

  // state index: 0 down, 1 up, 2 activating, 3 active
  function automatic logic [3:0] code_of(int s);
    case (s)
      0: code_of = 4'b1111;
      1: code_of = 4'b0111;
      2: code_of = 4'b0100;
      default: code_of = 4'b1100;
    endcase
  endfunction

  function automatic int model_next(int s, logic [3:0] c, logic cfg);
    if (c == 4'b1111) return 0;
    case (s)
      0: begin
        if (!cfg && c == 4'b0000) return 1;
        if (!cfg && c == 4'b1000) return 2;
        return 0;
      end
      1: return (c == 4'b1000) ? 2 : 1;
      default: return s;
    endcase
  endfunction

  task automatic check4(string req, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic send(logic [3:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic goto_state(int s);
    @(negedge clk); cfg_sel = 1'b0;
    @(negedge clk);
    send(4'b1111);
    if (s >= 1) send(4'b0000);
    if (s >= 2) send(4'b1000);
    if (s >= 3) begin
      @(negedge clk); line_active = 1'b1;
      @(negedge clk); line_active = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check4("R1 ind", ind_code, 4'b1111);
    check1("R1 clk_en", clk_en, 1'b1);
    check1("R1 fsync_en", fsync_en, 1'b1);

    // R3 code without strobe is ignored
    @(negedge clk); cmd_code = 4'b0000;
    @(negedge clk);
    check4("R3 no strobe", ind_code, 4'b1111);

    // R2 R3 R4 R5 R6 R8 sweep: every state x every code x cfg
    for (int cfg = 0; cfg < 2; cfg++) begin
      for (int s = 0; s < 4; s++) begin
        for (int c = 0; c < 16; c++) begin
          goto_state(s);
          check4("R2 reach", ind_code, code_of(s));
          @(negedge clk); cfg_sel = cfg[0];
          @(negedge clk);
          send(c[3:0]);
          check4("R3/R4/R5/R6/R8 sweep", ind_code,
                 code_of(model_next(s, c[3:0], cfg[0])));
        end
      end
    end

    // R9 R10 R11 clock stop with cfg_sel=1 in powered down
    goto_state(0);
    tick(); tick();
    check1("R9 on cfg0 down", clk_en, 1'b1);
    @(negedge clk); cfg_sel = 1'b1;
    @(negedge clk);
    check1("R10 no tick", clk_en, 1'b1);
    tick();
    check1("R9 stop clk", clk_en, 1'b0);
    check1("R11 stop fsync", fsync_en, 1'b0);

    // R7 software power-up
    @(negedge clk); sw_pwrup = 1'b1;
    @(negedge clk); sw_pwrup = 1'b0;
    check4("R7 sw_pwrup", ind_code, 4'b0111);
    check1("R10 hold until tick", clk_en, 1'b0);
    tick();
    check1("R10 clk on", clk_en, 1'b1);
    check1("R11 fsync lag", fsync_en, 1'b0);
    tick();
    check1("R11 fsync on", fsync_en, 1'b1);

    // R6 activate request ignored when down with cfg_sel=1
    send(4'b1111);
    check4("R4 deact", ind_code, 4'b1111);
    send(4'b1000);
    check4("R6 actreq ignored", ind_code, 4'b1111);
    tick();
    check1("R9 down cfg1", clk_en, 1'b0);

    // R7 clearing cfg_sel powers up
    @(negedge clk); cfg_sel = 1'b0;
    @(negedge clk);
    check4("R7 cfg fall", ind_code, 4'b0111);
    send(4'b1000);
    check4("R8 actreq from up", ind_code, 4'b0100);
    tick();
    check1("R9 clk back", clk_en, 1'b1);
    tick();
    check1("R11 fsync back", fsync_en, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule